// File: doc/BRIEF.md
# Extended-Precision Partial Remainder Unit

This block reduces one 80-bit extended-precision value (the dividend) modulo another (the divisor). The quotient is truncated toward zero, so the remainder keeps the dividend's sign and is always exact. Each operand is one sign bit, a 15-bit exponent biased by 16383, and a 64-bit significand with an explicit integer bit. A caller pulses `start_i` with both operands. The unit then runs a shift-and-subtract loop on the significands, retiring one quotient bit per clock. It normalizes the remainder, and finally pulses `done_o` together with the result, a four-bit condition vector and an invalid flag.

The exponent gap D is the dividend exponent minus the divisor exponent. When D is large, one pass would need too many iterations. In that case the unit retires only the top 33 quotient bits and flags the result as incomplete, so the caller can issue the operation again on the returned value. When D is small, the reduction completes and the three low quotient bits are exposed in the condition vector in a fixed, non-sequential placement. Special operand classes are resolved in a single cycle without entering the loop: zeros, infinities, NaNs, encodings outside the normal range, and dividends smaller in exponent than the divisor.

Top module: `xrem_unit`

## Requirements
- R1: During and after reset, `busy_o`, `done_o`, `res_o`, `cc_o` and `invalid_o` are all zero.
- R2: For two normal operands with 0 <= D < 64, `res_o` equals dividend - q*divisor, where q is the quotient truncated toward zero. The result carries the dividend's sign, its magnitude is below the divisor's, and `cc_o[2]` is 0.
- R3: After a complete reduction, quotient bit 2 appears on `cc_o[0]`, quotient bit 1 on `cc_o[3]` and quotient bit 0 on `cc_o[1]`.
- R4: For two normal operands with D >= 64, QQ = trunc(dividend / divisor / 2^(D-32)) and `res_o` equals dividend - divisor*QQ*2^(D-32). `cc_o` is 4'b0100.
- R5: A nonzero remainder is returned with its integer bit (bit 63) set. A zero remainder is returned as exponent 0 and significand 0, with the dividend's sign.
- R6: For two normal operands with D < 0, the dividend is returned unchanged and `cc_o` is 0.
- R7: An infinite dividend, or a zero divisor when neither operand is a NaN, sets `invalid_o`. The result is then the default NaN 80'hFFFF_C000_0000_0000_0000.
- R8: If the dividend is a NaN, it is returned with bit 62 forced to 1. Otherwise, if the divisor is a NaN, the divisor is returned the same way. In both cases `invalid_o` is 0.
- R9: A zero dividend with a non-NaN, nonzero divisor returns the same signed zero. A normal dividend with an infinite divisor returns the dividend unchanged. Neither case sets `invalid_o`.
- R10: An encoding that is neither zero, normal, infinite nor NaN is invalid: it sets `invalid_o` and returns the default NaN. This covers exponent 0 with a nonzero significand, and any nonzero exponent with bit 63 clear.
- R11: `start_i` is ignored while `busy_o` is 1. Each accepted start yields exactly one single-cycle `done_o`. `res_o`, `cc_o` and `invalid_o` hold their values from `done_o` until the next accepted start.
- R12: In every special case (R6 to R10), `cc_o` is 0 and `done_o` rises one cycle after the start is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Request pulse, accepted while idle |
| dvd_i | input | 80 | Dividend {sign, exponent[14:0], significand[63:0]} |
| dvs_i | input | 80 | Divisor, same layout |
| busy_o | output | 1 | Iteration in progress |
| done_o | output | 1 | One-cycle result strobe |
| res_o | output | 80 | Remainder or special result |
| cc_o | output | 4 | Condition vector; bit 2 marks an incomplete reduction |
| invalid_o | output | 1 | Invalid-operation flag |

## Verification
The operands are chosen to exercise each part of the result. Small integer pairs make the quotient low bits take distinct patterns, which checks the scrambled flag placement. Exact multiples and their negations check both the zero-remainder encoding and the sign rule. Exponent gaps of 0, 63, 64 and several hundred separate a complete reduction from a partial one on either side of the threshold, and a negative gap checks the pass-through path. Every special operand class and its priority is tried as well: NaN ahead of invalid, dividend NaN ahead of divisor NaN, and zero dividend against an infinite divisor. A run of pseudo-random normal pairs with mixed signs and gaps up to 71 is compared against a wide-integer reference model. A start raised during an iteration checks that no second result is produced.

// File: rtl/xrem_pkg.sv
package xrem_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_NORM = 2'd2
  } xr_state_e;

  typedef enum logic [2:0] {
    CL_ZERO = 3'd0,
    CL_NORM = 3'd1,
    CL_INF  = 3'd2,
    CL_NAN  = 3'd3,
    CL_BAD  = 3'd4
  } xr_class_e;

endpackage

// File: rtl/xrem_rst_sync.sv
module xrem_rst_sync (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) sync_q <= 2'b00;
    else          sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_o = sync_q[1];
endmodule

// File: rtl/xrem_classify.sv
module xrem_classify
  import xrem_pkg::*;
#(
  parameter int SIG_W = 64,
  parameter int EXP_W = 15
) (
  input  logic [SIG_W+EXP_W:0] dvd_i,
  input  logic [SIG_W+EXP_W:0] dvs_i,
  output logic                 spec_o,
  output logic [SIG_W+EXP_W:0] spec_res_o,
  output logic                 spec_inv_o
);
  localparam int FMT_W = 1 + EXP_W + SIG_W;
  localparam logic [FMT_W-1:0] DEF_NAN = {1'b1, {EXP_W{1'b1}}, 2'b11, {(SIG_W-2){1'b0}}};
  localparam logic [FMT_W-1:0] QBIT    = FMT_W'(1) << (SIG_W-2);

  function automatic xr_class_e kind_of(input logic [EXP_W-1:0] e, input logic [SIG_W-1:0] m);
    if (e == '0) return (m == '0) ? CL_ZERO : CL_BAD;
    if (e == '1) begin
      if (!m[SIG_W-1]) return CL_BAD;
      return (m[SIG_W-2:0] == '0) ? CL_INF : CL_NAN;
    end
    return m[SIG_W-1] ? CL_NORM : CL_BAD;
  endfunction

  logic [EXP_W-1:0] a_exp, b_exp;
  xr_class_e        a_cl, b_cl;

  assign a_exp = dvd_i[FMT_W-2 -: EXP_W];
  assign b_exp = dvs_i[FMT_W-2 -: EXP_W];
  assign a_cl  = kind_of(a_exp, dvd_i[SIG_W-1:0]);
  assign b_cl  = kind_of(b_exp, dvs_i[SIG_W-1:0]);

  always_comb begin
    spec_o     = 1'b1;
    spec_inv_o = 1'b0;
    spec_res_o = dvd_i;
    if (a_cl == CL_NAN) begin
      spec_res_o = dvd_i | QBIT;
    end else if (b_cl == CL_NAN) begin
      spec_res_o = dvs_i | QBIT;
    end else if (a_cl == CL_BAD || b_cl == CL_BAD || a_cl == CL_INF || b_cl == CL_ZERO) begin
      spec_inv_o = 1'b1;
      spec_res_o = DEF_NAN;
    end else if (a_cl == CL_ZERO || b_cl == CL_INF) begin
      spec_res_o = dvd_i;
    end else if (a_exp < b_exp) begin
      spec_res_o = dvd_i;
    end else begin
      spec_o = 1'b0;
    end
  end
endmodule

// File: rtl/xrem_divstep.sv
module xrem_divstep #(
  parameter int SIG_W = 64
) (
  input  logic [SIG_W:0]   rem_i,
  input  logic [SIG_W-1:0] dvs_i,
  input  logic             last_i,
  output logic [SIG_W:0]   rem_o,
  output logic             qbit_o
);
  logic [SIG_W:0] dvs_x, diff;

  assign dvs_x  = {1'b0, dvs_i};
  assign qbit_o = (rem_i >= dvs_x);
  assign diff   = qbit_o ? (rem_i - dvs_x) : rem_i;
  assign rem_o  = last_i ? diff : {diff[SIG_W-1:0], 1'b0};
endmodule

// File: rtl/xrem_norm.sv
module xrem_norm #(
  parameter int SIG_W = 64,
  parameter int EXP_W = 15
) (
  input  logic [SIG_W-1:0] rem_i,
  input  logic [EXP_W-1:0] frame_i,
  output logic [SIG_W-1:0] sig_o,
  output logic [EXP_W-1:0] exp_o,
  output logic             nz_o
);
  localparam int LZ_W = $clog2(SIG_W);

  logic [LZ_W-1:0] lz;

  always_comb begin
    lz = '0;
    for (int i = 0; i < SIG_W; i++) begin
      if (rem_i[i]) lz = LZ_W'(SIG_W - 1 - i);
    end
  end

  assign nz_o  = (rem_i != '0);
  assign sig_o = rem_i << lz;
  assign exp_o = nz_o ? (frame_i - EXP_W'(lz)) : '0;
endmodule

// File: rtl/xrem_unit.sv
module xrem_unit
  import xrem_pkg::*;
#(
  parameter int SIG_W  = 64,
  parameter int EXP_W  = 15,
  parameter int KEEP_N = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start_i,
  input  logic [SIG_W+EXP_W:0]   dvd_i,
  input  logic [SIG_W+EXP_W:0]   dvs_i,
  output logic                   busy_o,
  output logic                   done_o,
  output logic [SIG_W+EXP_W:0]   res_o,
  output logic [3:0]             cc_o,
  output logic                   invalid_o
);
  localparam int FMT_W = 1 + EXP_W + SIG_W;
  localparam int CNT_W = $clog2(SIG_W + 1);
  localparam int DIF_W = EXP_W + 2;
  localparam logic [FMT_W-1:0] DEF_NAN = {1'b1, {EXP_W{1'b1}}, 2'b11, {(SIG_W-2){1'b0}}};

  logic rst_sn;
  xrem_rst_sync u_rst (.clk(clk), .rst_n_i(rst_n), .rst_n_o(rst_sn));

  // operand fields
  logic             a_sgn;
  logic [EXP_W-1:0] a_exp, b_exp;
  logic [SIG_W-1:0] a_sig, b_sig;
  assign a_sgn = dvd_i[FMT_W-1];
  assign a_exp = dvd_i[FMT_W-2 -: EXP_W];
  assign b_exp = dvs_i[FMT_W-2 -: EXP_W];
  assign a_sig = dvd_i[SIG_W-1:0];
  assign b_sig = dvs_i[SIG_W-1:0];

  logic             spec;
  logic [FMT_W-1:0] spec_res;
  logic             spec_inv;
  xrem_classify #(.SIG_W(SIG_W), .EXP_W(EXP_W)) u_cls (
    .dvd_i(dvd_i), .dvs_i(dvs_i),
    .spec_o(spec), .spec_res_o(spec_res), .spec_inv_o(spec_inv)
  );

  // iteration plan derived from the exponent gap
  logic [DIF_W-1:0] gap;
  logic             part_w;
  logic [CNT_W-1:0] steps_w;
  logic [EXP_W-1:0] frame_w;
  assign gap     = {2'b00, a_exp} - {2'b00, b_exp};
  assign part_w  = (gap >= DIF_W'(SIG_W));
  assign steps_w = part_w ? CNT_W'(KEEP_N + 1) : (CNT_W'(gap) + CNT_W'(1));
  assign frame_w = part_w ? (a_exp - EXP_W'(KEEP_N)) : b_exp;

  // state
  xr_state_e        state_q, state_d;
  logic [SIG_W:0]   rem_q, rem_d;
  logic [SIG_W-1:0] dvs_q;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [EXP_W-1:0] frame_q;
  logic             sgn_q, part_q;
  logic [2:0]       qlo_q, qlo_d;
  logic [FMT_W-1:0] res_q, res_d;
  logic [3:0]       cc_q, cc_d;
  logic             inv_q, inv_d, done_q;

  // datapath pieces
  logic [SIG_W:0]   step_rem;
  logic             step_q;
  logic             last_step;
  assign last_step = (cnt_q == CNT_W'(1));

  xrem_divstep #(.SIG_W(SIG_W)) u_step (
    .rem_i(rem_q), .dvs_i(dvs_q), .last_i(last_step),
    .rem_o(step_rem), .qbit_o(step_q)
  );

  logic [SIG_W-1:0] n_sig;
  logic [EXP_W-1:0] n_exp;
  logic             n_nz;
  xrem_norm #(.SIG_W(SIG_W), .EXP_W(EXP_W)) u_norm (
    .rem_i(rem_q[SIG_W-1:0]), .frame_i(frame_q),
    .sig_o(n_sig), .exp_o(n_exp), .nz_o(n_nz)
  );

  // enables
  logic accept, spec_ld, op_ld, run_en, norm_en, out_we;
  assign accept  = (state_q == ST_IDLE) && start_i;
  assign spec_ld = accept && spec;
  assign op_ld   = accept && !spec;
  assign run_en  = (state_q == ST_RUN);
  assign norm_en = (state_q == ST_NORM);
  assign out_we  = spec_ld || norm_en;

  // next state
  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (op_ld) state_d = ST_RUN;
      ST_RUN:  if (last_step) state_d = ST_NORM;
      ST_NORM: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    rem_d = op_ld ? {1'b0, a_sig} : step_rem;
    cnt_d = op_ld ? steps_w : (cnt_q - CNT_W'(1));
    qlo_d = op_ld ? 3'b000 : {qlo_q[1:0], step_q};
  end

  always_comb begin
    if (spec_ld) begin
      res_d = spec_res;
      cc_d  = 4'b0000;
      inv_d = spec_inv;
    end else begin
      res_d = {sgn_q, n_exp, n_sig};
      cc_d  = part_q ? 4'b0100 : {qlo_q[1], 1'b0, qlo_q[0], qlo_q[2]};
      inv_d = 1'b0;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= out_we;
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      res_q <= '0;
      cc_q  <= '0;
      inv_q <= 1'b0;
    end else if (out_we) begin
      res_q <= res_d;
      cc_q  <= cc_d;
      inv_q <= inv_d;
    end
  end

  always_ff @(posedge clk) begin
    if (op_ld) begin
      dvs_q   <= b_sig;
      frame_q <= frame_w;
      sgn_q   <= a_sgn;
      part_q  <= part_w;
    end
    if (op_ld || run_en) begin
      rem_q <= rem_d;
      cnt_q <= cnt_d;
      qlo_q <= qlo_d;
    end
  end

  assign busy_o    = (state_q != ST_IDLE);
  assign done_o    = done_q;
  assign res_o     = res_q;
  assign cc_o      = cc_q;
  assign invalid_o = inv_q;

  // R11
  no_done_busy_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    done_o |-> !busy_o);
  // R11
  operand_hold_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    busy_o |=> (!busy_o || $stable(dvs_q)));
  // R11
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    !done_o |-> $stable(res_o));
  // R2
  rem_bound_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (state_q == ST_RUN) |-> (rem_q < {dvs_q, 1'b0}));
  // R2
  run_count_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (state_q == ST_RUN) |-> (cnt_q != '0));
  // R4
  partial_flags_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (done_o && cc_o[2]) |-> ((cc_o & 4'b1011) == 4'b0000));
  // R7
  invalid_nan_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (done_o && invalid_o) |-> (res_o == DEF_NAN));
  // R5
  normalized_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (done_o && !invalid_o && res_o[FMT_W-2 -: EXP_W] != '0 && res_o[FMT_W-2 -: EXP_W] != '1)
      |-> res_o[SIG_W-1]);
endmodule

// File: tb/xrem_unit_test.sv
module xrem_unit_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [79:0] DNAN = 80'hFFFF_C000_0000_0000_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [79:0] dvd_i = '0;
  logic [79:0] dvs_i = '0;
  logic        busy_o, done_o, invalid_o;
  logic [79:0] res_o;
  logic [3:0]  cc_o;

  xrem_unit uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .dvd_i(dvd_i), .dvs_i(dvs_i),
    .busy_o(busy_o), .done_o(done_o), .res_o(res_o), .cc_o(cc_o), .invalid_o(invalid_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;
  logic [84:0] exp_q[$];
  string       tag_q[$];
  logic [79:0] last_res;
  logic [63:0] seed = 64'h9E37_79B9_7F4A_7C15;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [79:0] got, input logic [79:0] want);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, want);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  function automatic logic [79:0] mk(input logic s, input logic [14:0] e, input logic [63:0] m);
    return {s, e, m};
  endfunction

  // 0 zero, 1 normal, 2 infinity, 3 NaN, 4 other
  function automatic int kind(input logic [79:0] x);
    logic [14:0] e = x[78:64];
    logic [63:0] m = x[63:0];
    if (e == 15'h0) return (m == 64'h0) ? 0 : 4;
    if (e == 15'h7FFF) begin
      if (!m[63]) return 4;
      return (m[62:0] == 63'h0) ? 2 : 3;
    end
    return m[63] ? 1 : 4;
  endfunction

  // returns {invalid, cc[3:0], result[79:0]}
  function automatic logic [84:0] ref_model(input logic [79:0] a, input logic [79:0] b);
    int ka = kind(a);
    int kb = kind(b);
    int d, lz;
    logic [127:0] num, qq, rr;
    logic [14:0]  fr;
    logic [3:0]   cc;
    logic [79:0]  r;
    if (ka == 3) return {1'b0, 4'b0, a | (80'h1 << 62)};
    if (kb == 3) return {1'b0, 4'b0, b | (80'h1 << 62)};
    if (ka == 4 || kb == 4 || ka == 2 || kb == 0) return {1'b1, 4'b0, DNAN};
    if (ka == 0 || kb == 2) return {1'b0, 4'b0, a};
    d = int'(a[78:64]) - int'(b[78:64]);
    if (d < 0) return {1'b0, 4'b0, a};
    num = {64'h0, a[63:0]} << ((d < 64) ? d : 32);
    qq  = num / {64'h0, b[63:0]};
    rr  = num % {64'h0, b[63:0]};
    fr  = (d < 64) ? b[78:64] : (a[78:64] - 15'd32);
    cc  = (d < 64) ? {qq[1], 1'b0, qq[0], qq[2]} : 4'b0100;
    if (rr[63:0] == 64'h0) begin
      r = {a[79], 15'h0, 64'h0};
    end else begin
      lz = 0;
      for (int i = 63; i >= 0; i--) begin
        if (rr[i]) break;
        lz++;
      end
      r = {a[79], fr - 15'(lz), rr[63:0] << lz};
    end
    return {1'b0, cc, r};
  endfunction

  function automatic logic [63:0] next_rand(input logic [63:0] x);
    logic [63:0] y = x;
    y = y ^ (y << 13);
    y = y ^ (y >> 7);
    y = y ^ (y << 17);
    return y;
  endfunction

  task automatic send(input logic [79:0] a, input logic [79:0] b, input string tag);
    @(negedge clk);
    while (busy_o) @(negedge clk);
    exp_q.push_back(ref_model(a, b));
    tag_q.push_back(tag);
    dvd_i   = a;
    dvs_i   = b;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic drain();
    @(negedge clk);
    while (busy_o || exp_q.size() != 0) @(negedge clk);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && done_o) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R11", "done without accepted start", {79'h0, done_o}, 80'h0);
      end else begin
        logic [84:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        last_res = e[79:0];
        check(res_o == e[79:0], t, "result", res_o, e[79:0]);
        check(cc_o == e[83:80], t, "cc", {76'h0, cc_o}, {76'h0, e[83:80]});
        check(invalid_o == e[84], t, "invalid", {79'h0, invalid_o}, {79'h0, e[84]});
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "R11", "watchdog expired", 80'h0, 80'h0);
    summary();
  end

  initial begin
    logic [79:0] one, two, three, six, seven, ten, thirteen, eight, pinf, pz, snan;
    one      = mk(0, 15'h3FFF, 64'h8000_0000_0000_0000);
    two      = mk(0, 15'h4000, 64'h8000_0000_0000_0000);
    three    = mk(0, 15'h4000, 64'hC000_0000_0000_0000);
    six      = mk(0, 15'h4001, 64'hC000_0000_0000_0000);
    seven    = mk(0, 15'h4001, 64'hE000_0000_0000_0000);
    eight    = mk(0, 15'h4002, 64'h8000_0000_0000_0000);
    ten      = mk(0, 15'h4002, 64'hA000_0000_0000_0000);
    thirteen = mk(0, 15'h4002, 64'hD000_0000_0000_0000);
    pinf     = mk(0, 15'h7FFF, 64'h8000_0000_0000_0000);
    pz       = 80'h0;
    snan     = mk(0, 15'h7FFF, 64'h8000_0000_0000_0001);

    repeat (3) @(negedge clk);
    // R1: outputs during reset
    check({busy_o, done_o, invalid_o, cc_o} == 7'h0 && res_o == 80'h0, "R1", "in reset",
          {72'h0, busy_o, done_o, invalid_o, cc_o, 1'b0}, 80'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check({busy_o, done_o, invalid_o, cc_o} == 7'h0 && res_o == 80'h0, "R1", "after reset",
          {72'h0, busy_o, done_o, invalid_o, cc_o, 1'b0}, 80'h0);

    // complete reductions, quotient low-bit placement
    send(seven, two, "R3");                       // q=3 r=1
    send(seven ^ (80'h1 << 79), two, "R2");       // sign follows dividend
    send(thirteen, three, "R3");                  // q=4 r=1
    send(thirteen, three ^ (80'h1 << 79), "R2");  // divisor sign ignored
    send(ten, three, "R3");                       // q=3 r=1
    send(three, two, "R2");                       // D=0
    send(six ^ (80'h1 << 79), three, "R5");       // zero remainder -> -0
    send(seven, mk(0, 15'h4000, 64'hE000_0000_0000_0000), "R5");
    send(mk(0, 15'h3FFF + 63, 64'hF123_4567_89AB_CDEF), mk(0, 15'h3FFF, 64'hC000_0000_0000_0001), "R2");
    // partial reductions
    send(mk(1, 15'h3FFF + 64, 64'hF123_4567_89AB_CDEF), mk(0, 15'h3FFF, 64'hC000_0000_0000_0001), "R4");
    send(mk(0, 15'h3FFF + 300, 64'h8765_4321_0FED_CBA9), three, "R4");
    // negative gap
    send(one, eight, "R6");
    // special classes
    send(pinf, two, "R7");
    send(two, pz, "R7");
    send(pz, pz, "R7");
    send(pinf, pinf, "R7");
    send(snan, two, "R8");
    send(two, snan ^ (80'h1 << 79), "R8");
    send(snan, mk(1, 15'h7FFF, 64'h8000_0000_0000_0002), "R8");
    send(pz ^ (80'h1 << 79), mk(0, 15'h4001, 64'hA000_0000_0000_0000), "R9");
    send(mk(0, 15'h4001, 64'hA000_0000_0000_0000), pinf ^ (80'h1 << 79), "R9");
    send(pz, pinf, "R9");
    send(mk(0, 15'h0, 64'h0000_0000_0000_0010), two, "R10");
    send(two, mk(0, 15'h3FFF, 64'h4000_0000_0000_0000), "R10");
    drain();

    // R12: special result one cycle after acceptance
    @(negedge clk);
    exp_q.push_back(ref_model(pinf, two));
    tag_q.push_back("R12");
    dvd_i = pinf; dvs_i = two; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check(done_o == 1'b1, "R12", "special latency", {79'h0, done_o}, 80'h1);
    drain();

    // R11: start during an iteration is ignored
    send(mk(0, 15'h3FFF + 40, 64'hABCD_EF01_2345_6789), three, "R11");
    dvd_i   = pinf;
    dvs_i   = pz;
    start_i = 1'b1;
    repeat (3) @(negedge clk);
    start_i = 1'b0;
    drain();
    repeat (60) @(negedge clk);
    check(res_o == last_res && !done_o, "R11", "hold after done", res_o, last_res);

    // pseudo-random normal operands
    for (int k = 0; k < 24; k++) begin
      logic [79:0] a, b;
      seed = next_rand(seed);
      a = mk(seed[0], 15'h3FFF + 15'(seed[15:8] % 72), seed[63:0] | 64'h8000_0000_0000_0000);
      seed = next_rand(seed);
      b = mk(seed[1], 15'h3FFF, seed[63:0] | 64'h8000_0000_0000_0000);
      send(a, b, (int'(a[78:64]) - int'(b[78:64]) >= 64) ? "R4" : "R2");
    end
    drain();
    repeat (5) @(negedge clk);
    summary();
  end
endmodule